// File: doc/BRIEF.md
# Instruction Cache Line Fill Controller

This block services misses for a two-way, 128-set instruction cache with four-word lines. When the fetch side reports a miss, the block captures the missed word address and the state of the indexed set. It then requests a four-word burst on a simple internal bus and picks the way that will receive the line. Each returned word is written into its own slot of that way. The first word to arrive is the one the fetch unit asked for, and it is forwarded at once so fetch can resume before the rest of the line lands.

Once the last word is in, the block writes the tag, sets the line valid and points the set's replacement bit at the other way. It also loads a burst buffer with the whole line, its tag and its set index. The cache arrays sit outside the block. The block reads the indexed set's valid, lock and LRU bits on its inputs and drives plain write strobes back to the arrays. Only one fill can be in flight at a time.

Top module: `icf_fill_top`

## Requirements
- R1: After reset, `busy`, `bus_req`, `fwd_valid`, `dwr_en`, `meta_wr_en` and `bb_valid` are all low.
- R2: A `miss_req` sampled while idle raises `busy` and `bus_req` on the next cycle. `bus_addr` is the missed word address times four, and both hold steady until `bus_rdy` is sampled high.
- R3: The word offset of the miss (word address bits [1:0]) is the critical index c. Beat i of the burst goes to word slot (c+i) mod 4, so a miss on word 2 fills slots 2, 3, 0, 1. Each beat gives a one-cycle `dwr_en` pulse one cycle after it is accepted, carrying the beat's data, the set index (word address bits [8:2]) and the victim way.
- R4: If neither way of the set is locked and at least one is invalid (`set_valid` bit k low), the fill goes to an invalid way. When both are invalid, way 0 is used.
- R5: If neither way is locked and both are valid, the fill goes to the way named by `set_lru`.
- R6: If exactly one way is locked (`set_lock` bit k high), the fill goes to the other way, whatever its valid and LRU state.
- R7: If both ways are locked, the burst still runs and the critical word is still forwarded and buffered. However, `dwr_en` and `meta_wr_en` never rise during that fill.
- R8: `fwd_valid` pulses for exactly one cycle per fill, one cycle after the first beat is accepted, with `fwd_data` equal to that beat's data.
- R9: `meta_wr_en` pulses for one cycle, one cycle after the fourth beat is accepted. In that pulse the way is the victim, the index is the set, `meta_tag` is word address bits [29:9], and `meta_lru` is the opposite way.
- R10: One cycle after the `meta_wr_en` cycle, `bb_valid` is high. `bb_tag` and `bb_index` hold the filled address, and `bb_line` holds slot k in bits [32k+31:32k].
- R11: A `miss_req` that arrives while `busy` is high is dropped: no second request is issued. `busy` falls one cycle after the `meta_wr_en` cycle.
- R12: A `bus_dvalid` that arrives outside the receive phase, whether idle or while waiting for `bus_rdy`, writes nothing and forwards nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_req | input | 1 | Miss reported by fetch side |
| miss_addr | input | 30 | Word address of the missed instruction |
| set_valid | input | 2 | Valid bits of the indexed set, one per way |
| set_lock | input | 2 | Lock bits of the indexed set, one per way |
| set_lru | input | 1 | Way that is least recently used in the indexed set |
| busy | output | 1 | A fill is in progress |
| bus_req | output | 1 | Burst read request |
| bus_addr | output | 32 | Byte address of the critical word |
| bus_rdy | input | 1 | Bus accepts the request |
| bus_dvalid | input | 1 | A burst beat is on `bus_data` |
| bus_data | input | 32 | Burst beat data |
| fwd_valid | output | 1 | Critical word is presented to fetch |
| fwd_data | output | 32 | Critical word |
| dwr_en | output | 1 | Data array word write strobe |
| dwr_way | output | 1 | Way written |
| dwr_index | output | 7 | Set written |
| dwr_word | output | 2 | Word slot written |
| dwr_data | output | 32 | Word written |
| meta_wr_en | output | 1 | Tag, valid and LRU write strobe |
| meta_way | output | 1 | Way whose tag is written and made valid |
| meta_index | output | 7 | Set whose metadata is written |
| meta_tag | output | 21 | Tag written |
| meta_lru | output | 1 | New LRU way for the set |
| bb_valid | output | 1 | Burst buffer holds a line |
| bb_tag | output | 21 | Tag of the buffered line |
| bb_index | output | 7 | Set of the buffered line |
| bb_line | output | 128 | Buffered line, slot k at bits [32k+31:32k] |

## Verification
Each result is due a fixed number of cycles after the input that causes it. `busy` and `bus_req` appear one cycle after an accepted miss. Each `dwr_en` pulse, and the `fwd_valid` pulse, appear one cycle after the beat that drives them. `meta_wr_en` appears one cycle after the fourth beat, and the burst buffer one cycle after that. The bench runs a behavioural reference model at the same clock edges the design uses and compares every output at the following falling edge. A result that comes a cycle early or late is therefore flagged in the cycle it goes wrong. The stimuli cover every victim case, variable bus latency, gaps between beats, stray beats and misses raised while a fill is running.

// File: rtl/icf_pkg.sv
// Shared types for the instruction cache line fill controller.
// Assumes: nothing beyond a standard SystemVerilog compile order.
package icf_pkg;

    // Phases of one line fill
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,   // waiting for a miss
        FS_REQ  = 2'd1,   // burst request raised, waiting for bus acceptance
        FS_RECV = 2'd2,   // collecting the four beats
        FS_DONE = 2'd3    // commit tag/valid/LRU and burst buffer
    } fill_state_e;

endpackage

// File: rtl/icf_victim_sel.sv
// Victim way selection for a two-way set.
// Order of choice: skip locked ways; among the rest prefer an invalid way
// (way 0 first), otherwise the LRU way. With both ways locked no way may be
// written and no_write is raised.
// Assumes: inputs are the state of the set being filled, sampled by the caller.
module icf_victim_sel (
    input  logic [1:0] set_valid,
    input  logic [1:0] set_lock,
    input  logic       set_lru,
    output logic       way,
    output logic       no_write
);

    // Pick the way to replace from lock, valid and LRU state
    always_comb begin
        way      = 1'b0;
        no_write = 1'b0;
        if (&set_lock) begin
            no_write = 1'b1;
        end else if (set_lock[0]) begin
            way = 1'b1;
        end else if (set_lock[1]) begin
            way = 1'b0;
        end else if (!set_valid[0]) begin
            way = 1'b0;
        end else if (!set_valid[1]) begin
            way = 1'b1;
        end else begin
            way = set_lru;
        end
    end

endmodule

// File: rtl/icf_beat_seq.sv
// Beat sequencer: tracks which word slot the next burst beat belongs to.
// Loaded with the critical word index when the bus accepts the request, then
// steps the slot modulo the line size on every beat (wraparound order).
// Assumes: load and beat are never high in the same cycle.
module icf_beat_seq #(
    parameter int WORD_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [WORD_BITS-1:0] crit_word,
    input  logic                 beat,
    output logic [WORD_BITS-1:0] cur_word,
    output logic                 first_beat,
    output logic                 last_beat
);

    logic [WORD_BITS-1:0] word_q;
    logic [WORD_BITS-1:0] cnt_q;

    // Slot pointer and beat count for the burst in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            word_q <= crit_word;
            cnt_q  <= '0;
        end else if (beat) begin
            word_q <= word_q + 1'b1;
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign cur_word   = word_q;
    assign first_beat = (cnt_q == '0);
    assign last_beat  = &cnt_q;

endmodule

// File: rtl/icf_line_asm.sv
// Line assembly and burst buffer.
// Collects the burst beats into a line register by word slot, then copies the
// whole line with its tag and set into the burst buffer on commit.
// Assumes: commit is a single-cycle pulse after the last beat.
module icf_line_asm #(
    parameter int DATA_W    = 32,
    parameter int WORD_BITS = 2,
    parameter int TAG_W     = 21,
    parameter int SET_BITS  = 7,
    localparam int LINE_WORDS = 1 << WORD_BITS,
    localparam int LINE_W     = DATA_W * LINE_WORDS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 beat,
    input  logic [WORD_BITS-1:0] beat_word,
    input  logic [DATA_W-1:0]    beat_data,
    input  logic                 commit,
    input  logic [TAG_W-1:0]     commit_tag,
    input  logic [SET_BITS-1:0]  commit_index,
    output logic                 bb_valid,
    output logic [TAG_W-1:0]     bb_tag,
    output logic [SET_BITS-1:0]  bb_index,
    output logic [LINE_W-1:0]    bb_line
);

    logic [LINE_W-1:0] asm_line;

    // One holding register per word slot
    for (genvar k = 0; k < LINE_WORDS; k++) begin : g_slot
        // Capture the beat that targets this slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                asm_line[k*DATA_W +: DATA_W] <= '0;
            end else if (beat && (beat_word == WORD_BITS'(k))) begin
                asm_line[k*DATA_W +: DATA_W] <= beat_data;
            end
        end
    end

    // Load the burst buffer with the finished line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bb_valid <= 1'b0;
            bb_tag   <= '0;
            bb_index <= '0;
            bb_line  <= '0;
        end else if (commit) begin
            bb_valid <= 1'b1;
            bb_tag   <= commit_tag;
            bb_index <= commit_index;
            bb_line  <= asm_line;
        end
    end

endmodule

// File: rtl/icf_fill_top.sv
// Line fill controller for a two-way set-associative instruction cache.
// Accepts one miss at a time, raises a burst read at the missed word, picks
// a victim way, writes each beat to its slot, forwards the critical word,
// commits tag/valid/LRU after the last beat and loads the burst buffer.
// Assumes: set_valid/set_lock/set_lru describe the set indexed by miss_addr
// in the cycle miss_req is high; the bus returns the critical word first and
// then wraps; arrays outside act on the write strobes.
module icf_fill_top
    import icf_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int SET_BITS  = 7,
    parameter int WORD_BITS = 2,
    localparam int WADDR_W    = ADDR_W - 2,
    localparam int TAG_W      = WADDR_W - SET_BITS - WORD_BITS,
    localparam int IDX_LO     = WORD_BITS,
    localparam int TAG_LO     = WORD_BITS + SET_BITS,
    localparam int LINE_W     = DATA_W * (1 << WORD_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 miss_req,
    input  logic [WADDR_W-1:0]   miss_addr,
    input  logic [1:0]           set_valid,
    input  logic [1:0]           set_lock,
    input  logic                 set_lru,
    output logic                 busy,
    output logic                 bus_req,
    output logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_rdy,
    input  logic                 bus_dvalid,
    input  logic [DATA_W-1:0]    bus_data,
    output logic                 fwd_valid,
    output logic [DATA_W-1:0]    fwd_data,
    output logic                 dwr_en,
    output logic                 dwr_way,
    output logic [SET_BITS-1:0]  dwr_index,
    output logic [WORD_BITS-1:0] dwr_word,
    output logic [DATA_W-1:0]    dwr_data,
    output logic                 meta_wr_en,
    output logic                 meta_way,
    output logic [SET_BITS-1:0]  meta_index,
    output logic [TAG_W-1:0]     meta_tag,
    output logic                 meta_lru,
    output logic                 bb_valid,
    output logic [TAG_W-1:0]     bb_tag,
    output logic [SET_BITS-1:0]  bb_index,
    output logic [LINE_W-1:0]    bb_line
);

    fill_state_e            state_q, state_d;
    logic [WADDR_W-1:0]     addr_q;
    logic                   vic_way_q, nowr_q;
    logic                   sel_way, sel_nowr;
    logic                   accept, bus_take, beat;
    logic [WORD_BITS-1:0]   cur_word;
    logic                   first_beat, last_beat;
    logic                   dwr_en_q, fwd_valid_q;
    logic [WORD_BITS-1:0]   dwr_word_q;
    logic [DATA_W-1:0]      dwr_data_q, fwd_data_q;
    logic [SET_BITS-1:0]    fill_index;
    logic [TAG_W-1:0]       fill_tag;

    assign accept     = (state_q == FS_IDLE) && miss_req;
    assign bus_take   = (state_q == FS_REQ) && bus_rdy;
    assign beat       = (state_q == FS_RECV) && bus_dvalid;
    assign fill_index = addr_q[IDX_LO +: SET_BITS];
    assign fill_tag   = addr_q[TAG_LO +: TAG_W];

    icf_victim_sel u_victim (
        .set_valid (set_valid),
        .set_lock  (set_lock),
        .set_lru   (set_lru),
        .way       (sel_way),
        .no_write  (sel_nowr)
    );

    icf_beat_seq #(.WORD_BITS(WORD_BITS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (bus_take),
        .crit_word  (addr_q[WORD_BITS-1:0]),
        .beat       (beat),
        .cur_word   (cur_word),
        .first_beat (first_beat),
        .last_beat  (last_beat)
    );

    icf_line_asm #(
        .DATA_W    (DATA_W),
        .WORD_BITS (WORD_BITS),
        .TAG_W     (TAG_W),
        .SET_BITS  (SET_BITS)
    ) u_line (
        .clk          (clk),
        .rst_n        (rst_n),
        .beat         (beat),
        .beat_word    (cur_word),
        .beat_data    (bus_data),
        .commit       (state_q == FS_DONE),
        .commit_tag   (fill_tag),
        .commit_index (fill_index),
        .bb_valid     (bb_valid),
        .bb_tag       (bb_tag),
        .bb_index     (bb_index),
        .bb_line      (bb_line)
    );

    // Next fill phase
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE: if (miss_req)              state_d = FS_REQ;
            FS_REQ:  if (bus_rdy)               state_d = FS_RECV;
            FS_RECV: if (beat && last_beat)     state_d = FS_DONE;
            FS_DONE:                            state_d = FS_IDLE;
            default:                            state_d = FS_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    // Capture miss address and victim choice when a miss is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            vic_way_q <= 1'b0;
            nowr_q    <= 1'b0;
        end else if (accept) begin
            addr_q    <= miss_addr;
            vic_way_q <= sel_way;
            nowr_q    <= sel_nowr;
        end
    end

    // Registered word write strobe and critical word forward
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dwr_en_q    <= 1'b0;
            dwr_word_q  <= '0;
            dwr_data_q  <= '0;
            fwd_valid_q <= 1'b0;
            fwd_data_q  <= '0;
        end else begin
            dwr_en_q    <= beat && !nowr_q;
            fwd_valid_q <= beat && first_beat;
            if (beat) begin
                dwr_word_q <= cur_word;
                dwr_data_q <= bus_data;
            end
            if (beat && first_beat) fwd_data_q <= bus_data;
        end
    end

    assign busy       = (state_q != FS_IDLE);
    assign bus_req    = (state_q == FS_REQ);
    assign bus_addr   = {addr_q, 2'b00};
    assign fwd_valid  = fwd_valid_q;
    assign fwd_data   = fwd_data_q;
    assign dwr_en     = dwr_en_q;
    assign dwr_way    = vic_way_q;
    assign dwr_index  = fill_index;
    assign dwr_word   = dwr_word_q;
    assign dwr_data   = dwr_data_q;
    assign meta_wr_en = (state_q == FS_DONE) && !nowr_q;
    assign meta_way   = vic_way_q;
    assign meta_index = fill_index;
    assign meta_tag   = fill_tag;
    assign meta_lru   = !vic_way_q;

endmodule

// File: rtl/icf_fill_chk.sv
// Protocol checker for the line fill controller, bound to icf_fill_top.
// Assumes: observes ports only.
module icf_fill_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              bus_req,
    input logic              bus_rdy,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              dwr_en,
    input logic              fwd_valid,
    input logic              meta_wr_en,
    input logic              bb_valid
);

    // R2: an unaccepted request stays up with the same address
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_rdy) |=> (bus_req && $stable(bus_addr)));

    // R2: a request is only raised during a fill
    assert_req_in_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> busy);

    // R8: the critical word forward lasts one cycle
    assert_fwd_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |=> !fwd_valid);

    // R9: metadata commit ends the fill
    assert_meta_ends_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        meta_wr_en |=> !busy);

    // R10: burst buffer holds a line after a commit
    assert_bb_after_meta_R10: assert property (@(posedge clk) disable iff (!rst_n)
        meta_wr_en |=> bb_valid);

    // R3: the metadata pulse never comes with the request still pending
    assert_meta_not_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        meta_wr_en |-> !bus_req);

endmodule

bind icf_fill_top icf_fill_chk #(.ADDR_W(ADDR_W)) u_fill_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .bus_req    (bus_req),
    .bus_rdy    (bus_rdy),
    .bus_addr   (bus_addr),
    .dwr_en     (dwr_en),
    .fwd_valid  (fwd_valid),
    .meta_wr_en (meta_wr_en),
    .bb_valid   (bb_valid)
);

// File: tb/icf_fill_top_tb_top.sv
// Bench for icf_fill_top: behavioural reference model stepped on each rising
// edge, every output compared on the following falling edge.
module icf_fill_top_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         miss_req = 1'b0;
    logic [29:0]  miss_addr = '0;
    logic [1:0]   set_valid = '0;
    logic [1:0]   set_lock = '0;
    logic         set_lru = 1'b0;
    logic         busy, bus_req;
    logic [31:0]  bus_addr;
    logic         bus_rdy = 1'b0;
    logic         bus_dvalid = 1'b0;
    logic [31:0]  bus_data = '0;
    logic         fwd_valid;
    logic [31:0]  fwd_data;
    logic         dwr_en, dwr_way;
    logic [6:0]   dwr_index;
    logic [1:0]   dwr_word;
    logic [31:0]  dwr_data;
    logic         meta_wr_en, meta_way, meta_lru;
    logic [6:0]   meta_index;
    logic [20:0]  meta_tag;
    logic         bb_valid;
    logic [20:0]  bb_tag;
    logic [6:0]   bb_index;
    logic [127:0] bb_line;

    int    n_tests = 0;
    int    n_fail = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string vtag = "R4";

    always #2 clk = ~clk;

    icf_fill_top dut_i (
        .clk(clk), .rst_n(rst_n), .miss_req(miss_req), .miss_addr(miss_addr),
        .set_valid(set_valid), .set_lock(set_lock), .set_lru(set_lru),
        .busy(busy), .bus_req(bus_req), .bus_addr(bus_addr), .bus_rdy(bus_rdy),
        .bus_dvalid(bus_dvalid), .bus_data(bus_data),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data),
        .dwr_en(dwr_en), .dwr_way(dwr_way), .dwr_index(dwr_index),
        .dwr_word(dwr_word), .dwr_data(dwr_data),
        .meta_wr_en(meta_wr_en), .meta_way(meta_way), .meta_index(meta_index),
        .meta_tag(meta_tag), .meta_lru(meta_lru),
        .bb_valid(bb_valid), .bb_tag(bb_tag), .bb_index(bb_index), .bb_line(bb_line)
    );

    task automatic chk(input string tag, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Reference victim rule, written from the requirements
    function automatic void ref_pick(input logic [1:0] v, input logic [1:0] l,
                                     input logic lru, output logic w, output logic nw);
        int freeq[$];
        w = 1'b0;
        nw = 1'b0;
        for (int k = 0; k < 2; k++) if (!l[k]) freeq.push_back(k);
        if (freeq.size() == 0) nw = 1'b1;
        else if (freeq.size() == 1) w = freeq[0][0];
        else begin
            w = lru;
            for (int k = 1; k >= 0; k--) if (!v[k]) w = k[0];
        end
    endfunction

    // Reference model state: 0 idle, 1 request, 2 receive, 3 commit
    int          m_st = 0;
    logic [29:0] m_addr = '0;
    logic        m_way = 1'b0, m_nowr = 1'b0;
    int          m_q[$];
    bit          m_first = 1'b0;
    logic [31:0] m_line [4];
    logic        e_dwr_en = 1'b0, e_fwd = 1'b0, e_bb_valid = 1'b0;
    logic [1:0]  e_dwr_word = '0;
    logic [31:0] e_dwr_data = '0, e_fwd_data = '0;
    logic [20:0] e_bb_tag = '0;
    logic [6:0]  e_bb_index = '0;
    logic [127:0] e_bb_line = '0;

    // Step the reference model on the same edge as the design
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; e_dwr_en = 0; e_fwd = 0; e_bb_valid = 0; m_q.delete();
        end else begin
            e_dwr_en = 0;
            e_fwd = 0;
            case (m_st)
                0: if (miss_req) begin
                    m_addr = miss_addr;
                    ref_pick(set_valid, set_lock, set_lru, m_way, m_nowr);
                    m_st = 1;
                end
                1: if (bus_rdy) begin
                    for (int i = 0; i < 4; i++) m_q.push_back((int'(m_addr[1:0]) + i) % 4);
                    m_first = 1'b1;
                    m_st = 2;
                end
                2: if (bus_dvalid) begin
                    int w;
                    w = m_q.pop_front();
                    m_line[w] = bus_data;
                    e_dwr_en = !m_nowr;
                    e_dwr_word = w[1:0];
                    e_dwr_data = bus_data;
                    if (m_first) begin
                        e_fwd = 1'b1;
                        e_fwd_data = bus_data;
                    end
                    m_first = 1'b0;
                    if (m_q.size() == 0) m_st = 3;
                end
                default: begin
                    e_bb_valid = 1'b1;
                    e_bb_tag = m_addr[29:9];
                    e_bb_index = m_addr[8:2];
                    e_bb_line = {m_line[3], m_line[2], m_line[1], m_line[0]};
                    m_st = 0;
                end
            endcase
        end
    end

    // Compare every output against the model away from the rising edge
    always @(negedge clk) begin
        if (chk_on) begin
            string wtag;
            wtag = m_nowr ? "R7" : "R3";
            chk("R11", "busy", busy, m_st != 0);
            chk("R2", "bus_req", bus_req, m_st == 1);
            if (m_st == 1) chk("R2", "bus_addr", bus_addr, {m_addr, 2'b00});
            chk(wtag, "dwr_en", dwr_en, e_dwr_en);
            if (e_dwr_en) begin
                chk("R3", "dwr_word", dwr_word, e_dwr_word);
                chk("R3", "dwr_data", dwr_data, e_dwr_data);
                chk("R3", "dwr_index", dwr_index, m_addr[8:2]);
                chk(vtag, "dwr_way", dwr_way, m_way);
            end
            chk("R8", "fwd_valid", fwd_valid, e_fwd);
            if (e_fwd) chk("R8", "fwd_data", fwd_data, e_fwd_data);
            chk(m_nowr ? "R7" : "R9", "meta_wr_en", meta_wr_en, (m_st == 3) && !m_nowr);
            if ((m_st == 3) && !m_nowr) begin
                chk(vtag, "meta_way", meta_way, m_way);
                chk("R9", "meta_index", meta_index, m_addr[8:2]);
                chk("R9", "meta_tag", meta_tag, m_addr[29:9]);
                chk("R9", "meta_lru", meta_lru, !m_way);
            end
            chk("R10", "bb_valid", bb_valid, e_bb_valid);
            if (e_bb_valid) begin
                chk("R10", "bb_tag", bb_tag, e_bb_tag);
                chk("R10", "bb_index", bb_index, e_bb_index);
                chk("R10", "bb_line", bb_line, e_bb_line);
            end
        end
    end

    // One complete fill; poke adds a stray beat in the request phase (R12)
    // and a miss raised mid-burst (R11)
    task automatic do_fill(input logic [29:0] a, input logic [1:0] v, input logic [1:0] l,
                           input logic lru, input int rdy_dly, input int gap,
                           input string tag, input bit poke);
        vtag = tag;
        @(negedge clk);
        miss_req = 1'b1; miss_addr = a; set_valid = v; set_lock = l; set_lru = lru;
        @(negedge clk);
        miss_req = 1'b0;
        for (int d = 0; d < rdy_dly; d++) begin
            bus_dvalid = poke && (d == 0);
            bus_data = 32'hDEAD_0000 | a[15:0];
            @(negedge clk);
            bus_dvalid = 1'b0;
        end
        bus_rdy = 1'b1;
        @(negedge clk);
        bus_rdy = 1'b0;
        for (int i = 0; i < 4; i++) begin
            for (int g = 0; g < gap; g++) @(negedge clk);
            bus_dvalid = 1'b1;
            bus_data = {a[13:0], 14'h0, i[3:0]} ^ 32'h5A5A_0F0F;
            if (poke && i == 1) begin
                miss_req = 1'b1;
                miss_addr = a ^ 30'h155;
            end
            @(negedge clk);
            bus_dvalid = 1'b0;
            miss_req = 1'b0;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1'b1;
        // R1: reset state
        chk("R1", "busy", busy, 0);
        chk("R1", "bus_req", bus_req, 0);
        chk("R1", "fwd_valid", fwd_valid, 0);
        chk("R1", "dwr_en", dwr_en, 0);
        chk("R1", "meta_wr_en", meta_wr_en, 0);
        chk("R1", "bb_valid", bb_valid, 0);
        // R12: stray beat while idle writes and forwards nothing
        @(negedge clk);
        bus_dvalid = 1'b1; bus_data = 32'hBAD0_BEEF;
        @(negedge clk);
        bus_dvalid = 1'b0;
        chk("R12", "dwr_en after idle beat", dwr_en, 0);
        chk("R12", "fwd_valid after idle beat", fwd_valid, 0);
        // R4: both invalid, critical word 0
        do_fill(30'h0000_1230, 2'b00, 2'b00, 1'b1, 0, 0, "R4", 0);
        // R4: way 0 valid so way 1, critical word 2, slow bus and gaps
        do_fill(30'h0ABC_4566, 2'b01, 2'b00, 1'b0, 2, 1, "R4", 0);
        // R5: both valid, LRU names way 1, critical word 1
        do_fill(30'h1234_5671, 2'b11, 2'b00, 1'b1, 1, 0, "R5", 0);
        // R5: both valid, LRU names way 0, critical word 3, stray beat and mid-fill miss
        do_fill(30'h2FED_CBA3, 2'b11, 2'b00, 1'b0, 3, 2, "R5", 1);
        // R6: way 0 locked, LRU points at it, way 1 used
        do_fill(30'h0000_7F02, 2'b11, 2'b01, 1'b0, 0, 1, "R6", 0);
        // R6: way 1 locked, way 1 invalid yet way 0 used
        do_fill(30'h3000_0011, 2'b01, 2'b10, 1'b1, 1, 0, "R6", 0);
        // R7: both locked, no array writes, forward and buffer still happen
        do_fill(30'h1111_2222, 2'b11, 2'b11, 1'b0, 1, 1, "R7", 0);
        chk("R7", "bb_tag after locked fill", bb_tag, 21'(30'h1111_2222 >> 9));
        // Back-to-back fill right after a commit
        do_fill(30'h0000_0003, 2'b10, 2'b00, 1'b1, 0, 0, "R4", 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule